// File: doc/BRIEF.md
# Line-Locked 4:2:2 Chroma Output Formatter

This block takes a stream of full-rate pixels, each carrying one luma sample and two chroma samples, and produces a 4:2:2 output. Luma leaves on its own bus at full rate. A second bus carries chroma at half rate: it alternates between the blue-difference and red-difference components. Both components of a pair are taken from the even pixel of the pair. The red-difference sample of an even pixel is held for one beat, so that it goes out beside the luma of the following odd pixel. The chroma of odd pixels is dropped.

The chroma phase is locked to an already aligned line-sync input. On the beat where that sync shows its leading edge, the phase returns to blue-difference, so the first pixel of every line carries Cb. Sync goes through the same pipeline as the data, so the offset between output sync and output data stays even (zero beats). The whole path is a fixed-length pipeline that advances only on beats where the input valid strobe is high. Every valid beat is accepted, so there is no ready signal and no back-pressure: a display path cannot stall, and an idle beat simply freezes the pipeline and its outputs.

Top module: `fmt422_top`

## Requirements
- R1: On every valid beat the luma output advances by one pixel and carries the luma samples in arrival order, with no pixel skipped or repeated.
- R2: The chroma output alternates: on the first beat of a pair it carries the Cb of that (even) pixel, and on the second beat the Cr of the same even pixel. The Cb and Cr presented with the odd pixel never reach the output.
- R3: A sync leading edge is a valid beat with sync high whose previous valid beat had sync low (after reset the previous value counts as low). On that beat the phase is forced to Cb, whatever phase was pending.
- R4: The sync output is the sync input delayed by the same number of valid beats as the data, so the sync-to-data offset is zero beats (an even number).
- R5: The output path has a latency of LAT valid beats (default 8). With the valid strobe held high this is LAT clock cycles from input to output.
- R6: On a clock where the valid strobe is low, the luma, chroma and sync outputs keep their values and the chroma phase does not advance.
- R7: While reset (active-low) is asserted and until LAT valid beats have been accepted afterwards, all outputs are zero. The first valid beat after reset is in the Cb phase.
- R8: Sync held high over several consecutive valid beats counts as one edge only; the later high beats do not reset the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_vld_i | input | 1 | Input beat valid strobe |
| y_i | input | 8 | Luma of the input pixel |
| cb_i | input | 8 | Blue-difference chroma of the input pixel |
| cr_i | input | 8 | Red-difference chroma of the input pixel |
| sync_i | input | 1 | Aligned line sync, active high |
| y_o | output | 8 | Luma output |
| c_o | output | 8 | Interleaved Cb/Cr output |
| sync_o | output | 1 | Line sync aligned with the outputs |

## Verification
A wrong phase bit shows at the ports as Cb and Cr swapped on the chroma bus. This appears exactly LAT valid beats after the beat that went wrong, and the next sync edge puts it right again. A stale or wrongly captured red-difference hold register shows as a Cr value that does not match the Cb of the beat before. A pipeline that moves on an idle clock shows as an output change during a valid-low gap, or as a latency that differs from LAT valid beats. Both show up within one line of pixels.

// File: rtl/fmt422_pkg.sv
package fmt422_pkg;
  parameter int unsigned PIX_W = 8;

  typedef struct packed {
    logic             sync;
    logic [PIX_W-1:0] c;
    logic [PIX_W-1:0] y;
  } fmt_beat_t;
endpackage

// File: rtl/chroma_phaser.sv
module chroma_phaser
  import fmt422_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld,
  input  logic [PIX_W-1:0] y,
  input  logic [PIX_W-1:0] cb,
  input  logic [PIX_W-1:0] cr,
  input  logic             sync,
  output fmt_beat_t        q
);
  logic             ph_cr;
  logic             sync_prev;
  logic [PIX_W-1:0] cr_hold;
  logic             lead_edge;
  logic             use_cr;

  assign lead_edge = sync & ~sync_prev;
  assign use_cr    = ph_cr & ~lead_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q         <= '0;
      ph_cr     <= 1'b0;
      sync_prev <= 1'b0;
      cr_hold   <= '0;
    end else if (vld) begin
      q.y       <= y;
      q.sync    <= sync;
      q.c       <= use_cr ? cr_hold : cb;
      if (!use_cr) cr_hold <= cr;
      ph_cr     <= ~use_cr;
      sync_prev <= sync;
    end
  end

  // R3: a leading edge of sync always emits Cb of that pixel
  p_cb_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && sync && !sync_prev) |=> (q.c == $past(cb)));

  // R2: a Cr beat emits the red-difference captured on the previous Cb beat
  p_cr_from_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && ph_cr && !(sync && !sync_prev)) |=> (q.c == $past(cr_hold)));

  // R6: idle beat freezes stage and phase
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> ($stable(q) && $stable(ph_cr)));
endmodule

// File: rtl/beat_delay.sv
module beat_delay
  import fmt422_pkg::*;
#(
  parameter int unsigned DEPTH = 7
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  fmt_beat_t d,
  output fmt_beat_t q
);
  fmt_beat_t st [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n)  st[g] <= '0;
        else if (en) st[g] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rst_n)  st[g] <= '0;
        else if (en) st[g] <= st[g-1];
      end
    end
  end

  assign q = st[DEPTH-1];
endmodule

// File: rtl/fmt422_top.sv
module fmt422_top
  import fmt422_pkg::*;
#(
  parameter int unsigned LAT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_vld_i,
  input  logic [PIX_W-1:0] y_i,
  input  logic [PIX_W-1:0] cb_i,
  input  logic [PIX_W-1:0] cr_i,
  input  logic             sync_i,
  output logic [PIX_W-1:0] y_o,
  output logic [PIX_W-1:0] c_o,
  output logic             sync_o
);
  localparam int unsigned TAIL = (LAT > 1) ? LAT - 1 : 1;

  fmt_beat_t head_q;
  fmt_beat_t tail_q;

  chroma_phaser u_phase (
    .clk  (clk),
    .rst_n(rst_n),
    .vld  (pix_vld_i),
    .y    (y_i),
    .cb   (cb_i),
    .cr   (cr_i),
    .sync (sync_i),
    .q    (head_q)
  );

  beat_delay #(.DEPTH(TAIL)) u_tail (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (pix_vld_i),
    .d    (head_q),
    .q    (tail_q)
  );

  assign y_o    = tail_q.y;
  assign c_o    = tail_q.c;
  assign sync_o = tail_q.sync;

  // R6: outputs hold across an idle clock
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld_i |=> ($stable(y_o) && $stable(c_o) && $stable(sync_o)));

  // R7: outputs are zero on the first clock out of reset
  p_reset_zero_r7: assert property (@(posedge clk)
    $rose(rst_n) |-> (y_o == '0 && c_o == '0 && !sync_o));
endmodule

// File: tb/fmt422_top_test.sv
module fmt422_top_test;
  localparam int LAT = 8;
  localparam int MAXB = 4096;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic [7:0] y = '0, cb = '0, cr = '0;
  logic       sync = 1'b0;
  logic [7:0] y_o, c_o;
  logic       sync_o;

  fmt422_top #(.LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .pix_vld_i(vld), .y_i(y), .cb_i(cb),
    .cr_i(cr), .sync_i(sync), .y_o(y_o), .c_o(c_o), .sync_o(sync_o)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  // reference model state
  logic [7:0] ey [MAXB];
  logic [7:0] ec [MAXB];
  logic       es [MAXB];
  int   nb = 0;
  logic m_cr = 1'b0;
  logic m_prev = 1'b0;
  logic [7:0] m_hold = '0;

  function automatic logic [7:0] pick_c(input logic use_cr, input logic [7:0] hold,
                                        input logic [7:0] cbv);
    return use_cr ? hold : cbv;
  endfunction

  task automatic model_beat(input logic [7:0] yv, cbv, crv, input logic sv);
    logic edge_seen, use_cr;
    edge_seen = sv && !m_prev;
    use_cr = m_cr && !edge_seen;
    ey[nb] = yv;
    ec[nb] = pick_c(use_cr, m_hold, cbv);
    es[nb] = sv;
    if (!use_cr) m_hold = crv;
    m_cr = !use_cr;
    m_prev = sv;
    nb++;
  endtask

  task automatic check_out(input string tag);
    logic [7:0] xy, xc;
    logic xs;
    if (nb >= LAT) begin
      xy = ey[nb-LAT]; xc = ec[nb-LAT]; xs = es[nb-LAT];
    end else begin
      xy = '0; xc = '0; xs = 1'b0;
    end
    checks++;
    if (y_o !== xy || c_o !== xc || sync_o !== xs) begin
      errors++;
      $display("FAIL %s beat %0d: y=%0h c=%0h s=%0b expected y=%0h c=%0h s=%0b",
               tag, nb, y_o, c_o, sync_o, xy, xc, xs);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] yv, cbv, crv,
                      input logic sv, input string tag);
    vld = v; y = yv; cb = cbv; cr = crv; sync = sv;
    @(posedge clk); #1;
    if (v) model_beat(yv, cbv, crv, sv);
    check_out(tag);
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < LAT; i++) step(1'b1, 8'(i), 8'hA0, 8'hB0, 1'b0, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int seed_junk;
    seed_junk = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    #1;
    // R7: zero during reset
    check_out("R7");
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_out("R7");

    // R7/R1/R5: first beats after reset, Cb phase first, continuous valid
    for (int i = 0; i < 12; i++)
      step(1'b1, 8'(8'h10 + i), 8'(8'h40 + i), 8'(8'h80 + i), 1'b0,
           (i < LAT) ? "R7" : "R5");

    // R2: odd pixels carry distinct chroma that must never show
    for (int i = 0; i < 10; i++)
      step(1'b1, 8'(i), (i % 2) ? 8'hEE : 8'(8'h20 + i),
           (i % 2) ? 8'hDD : 8'(8'h60 + i), 1'b0, "R2");
    flush("R2");

    // R3/R4: edge arriving while Cr phase is pending forces Cb
    step(1'b1, 8'h01, 8'h11, 8'h21, 1'b0, "R3");
    step(1'b1, 8'h02, 8'h12, 8'h22, 1'b1, "R3");
    step(1'b1, 8'h03, 8'h13, 8'h23, 1'b0, "R4");
    step(1'b1, 8'h04, 8'h14, 8'h24, 1'b0, "R4");
    flush("R4");

    // R8: sync held high for several beats is one edge
    for (int i = 0; i < 6; i++)
      step(1'b1, 8'(8'h30 + i), 8'(8'h50 + i), 8'(8'h70 + i), (i < 4), "R8");
    flush("R8");

    // R6: idle clocks hold outputs and phase
    step(1'b1, 8'h91, 8'h92, 8'h93, 1'b0, "R6");
    for (int i = 0; i < 3; i++) step(1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b1, "R6");
    step(1'b1, 8'h94, 8'h95, 8'h96, 1'b0, "R6");
    flush("R6");

    // random mix: gaps, line syncs of varying width, random pixels
    for (int i = 0; i < 2500; i++) begin
      logic v, s;
      v = ($urandom % 4) != 0;
      s = (($urandom % 37) == 0) || (sync && (($urandom % 2) == 0));
      step(v, 8'($urandom), 8'($urandom), 8'($urandom), s,
           v ? (s ? "R3" : "R1") : "R6");
    end
    flush("R5");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule